// File: doc/BRIEF.md
# Buffered Memory Write Path

This block takes 128-bit words from a video codec and turns each one into a single-beat write toward a memory controller. The codec presents a word and raises an active-high enable for one cycle. The word goes into a local first-in first-out buffer, so the codec never waits on the memory side. A small sequencer then takes the oldest buffered word and raises a write request toward the command arbiter, together with the address for that word. It also presents the word on the controller's write-data channel, with a write-enable, an end-of-burst marker and a ready return.

The command and its data beat finish independently. The controller may take the data beat in the same cycle as the command, before it, or some cycles after it. Its data ready can trail command acceptance by two cycles or more. The sequencer keeps the word and its enable steady until ready is seen. A word leaves the buffer only when its data beat is taken, so each word is written exactly once. Addresses start at 8 and go up by 8 for each accepted command. If the codec writes while the buffer is full, the word is lost and a sticky overflow flag is raised.

Top module: `mwb_write_path`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous) and after it is released, cmd_req, wd_wren, wd_last and wr_overflow are 0, cmd_addr is 8 and the buffer is empty.
- R2: A word on in_data is stored at a rising edge where in_en is 1 and the buffer is not full. Stored words go out on wd_data in arrival order.
- R3: Each stored word produces exactly one accepted command (cmd_req and cmd_grant both 1 at an edge) and exactly one accepted data beat (wd_wren and wd_rdy both 1 at an edge), with no repeats.
- R4: Once wd_wren is 1, it stays 1 and wd_data stays unchanged until an edge where wd_rdy is 1.
- R5: wd_last equals wd_wren in every cycle, so every beat ends its burst.
- R6: While a command is pending, the matching word is already offered with wd_wren at 1. If the beat is taken first, wd_wren drops in the next cycle while cmd_req stays 1 until the command is taken.
- R7: If the command is taken first, cmd_req drops in the next cycle while wd_wren stays 1 for as many cycles as wd_rdy stays low (two or more included).
- R8: cmd_addr holds its value while a command is pending. It is 8 for the first command after reset and goes up by 8 after each accepted command.
- R9: The buffer holds 512 words. A word offered with in_en while 512 words are held is dropped and is never written. wr_overflow then goes to 1 and stays 1 until reset.
- R10: A reset in the middle of a transfer stops the request, empties the buffer and clears the overflow flag. The next command after release carries address 8 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_en | input | 1 | Input word strobe, active high |
| in_data | input | 128 | Word from the codec |
| cmd_req | output | 1 | Write command request toward the arbiter |
| cmd_addr | output | 28 | Address for the pending write command |
| cmd_grant | input | 1 | Command accepted in this cycle |
| wd_data | output | 128 | Write-data beat |
| wd_wren | output | 1 | Write-data valid |
| wd_last | output | 1 | End-of-burst marker |
| wd_rdy | input | 1 | Controller can take the data beat |
| wr_overflow | output | 1 | Sticky flag: an input word was dropped |

## Verification
The words are drained under three handshake orderings: command and beat in the same cycle, beat one cycle before the command, and command first with ready arriving two or five cycles later. These orderings separate a sequencer that pops too early, repeats a beat or drops the request after a beat from one that keeps both halves apart. A fill of all 512 entries with the controller stalled, followed by one extra word, checks where the buffer boundary lies and that the dropped word never appears. A reset in the middle of a request shows that the flag, buffer and address all return to their starting values.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2
    } wr_state_e;

endpackage

// File: rtl/mwb_fifo.sv
module mwb_fifo #(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full,
    output logic              dropped
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } fifo_state_t;

    fifo_state_t      st_d, st_q;
    logic [DATA_W-1:0] store [DEPTH];
    logic             do_push;
    logic             do_pop;

    always_comb begin
        empty   = (st_q.count == '0);
        full    = (st_q.count == CNT_MAX);
        do_push = push && !full;
        do_pop  = pop && !empty;
        dropped = push && full;

        st_d = st_q;
        if (do_push) begin
            st_d.wr_ptr = st_q.wr_ptr + PTR_W'(1);
        end
        if (do_pop) begin
            st_d.rd_ptr = st_q.rd_ptr + PTR_W'(1);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + CNT_W'(1);
            2'b01:   st_d.count = st_q.count - CNT_W'(1);
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[st_q.wr_ptr] <= push_data;
        end
    end

    assign head = store[st_q.rd_ptr];

endmodule

// File: rtl/mwb_seq.sv
module mwb_seq
    import mwb_pkg::*;
#(
    parameter int ADDR_W    = 28,
    parameter int ADDR_INIT = 8,
    parameter int ADDR_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              have_word,
    input  logic              cmd_grant,
    input  logic              wd_rdy,
    output logic              cmd_req,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wd_wren,
    output logic              pop
);

    localparam logic [ADDR_W-1:0] ADDR_START = ADDR_W'(ADDR_INIT);
    localparam logic [ADDR_W-1:0] ADDR_INC   = ADDR_W'(ADDR_STEP);

    typedef struct packed {
        wr_state_e         st;
        logic              beat_done;
        logic [ADDR_W-1:0] addr;
    } seq_state_t;

    seq_state_t seq_d, seq_q;
    logic       beat;

    always_comb begin
        seq_d   = seq_q;
        cmd_req = 1'b0;
        wd_wren = 1'b0;
        beat    = 1'b0;

        case (seq_q.st)
            ST_IDLE: begin
                seq_d.beat_done = 1'b0;
                if (have_word) begin
                    seq_d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                cmd_req = 1'b1;
                wd_wren = !seq_q.beat_done;
                beat    = wd_wren && wd_rdy;
                if (cmd_grant) begin
                    seq_d.addr = seq_q.addr + ADDR_INC;
                    if (beat || seq_q.beat_done) begin
                        seq_d.st        = ST_IDLE;
                        seq_d.beat_done = 1'b0;
                    end else begin
                        seq_d.st = ST_DATA;
                    end
                end else if (beat) begin
                    seq_d.beat_done = 1'b1;
                end
            end
            ST_DATA: begin
                wd_wren = 1'b1;
                beat    = wd_rdy;
                if (wd_rdy) begin
                    seq_d.st = ST_IDLE;
                end
            end
            default: begin
                seq_d.st        = ST_IDLE;
                seq_d.beat_done = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st        <= ST_IDLE;
            seq_q.beat_done <= 1'b0;
            seq_q.addr      <= ADDR_START;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pop      = beat;
    assign cmd_addr = seq_q.addr;

endmodule

// File: rtl/mwb_write_path.sv
module mwb_write_path #(
    parameter int DATA_W    = 128,
    parameter int DEPTH     = 512,
    parameter int ADDR_W    = 28,
    parameter int ADDR_INIT = 8,
    parameter int ADDR_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_en,
    input  logic [DATA_W-1:0] in_data,
    output logic              cmd_req,
    output logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_grant,
    output logic [DATA_W-1:0] wd_data,
    output logic              wd_wren,
    output logic              wd_last,
    input  logic              wd_rdy,
    output logic              wr_overflow
);

    typedef struct packed {
        logic ovf;
    } top_state_t;

    top_state_t top_d, top_q;
    logic       buf_empty;
    logic       buf_full;
    logic       buf_drop;
    logic       buf_pop;

    mwb_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_en),
        .push_data (in_data),
        .pop       (buf_pop),
        .head      (wd_data),
        .empty     (buf_empty),
        .full      (buf_full),
        .dropped   (buf_drop)
    );

    mwb_seq #(
        .ADDR_W    (ADDR_W),
        .ADDR_INIT (ADDR_INIT),
        .ADDR_STEP (ADDR_STEP)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .have_word (!buf_empty),
        .cmd_grant (cmd_grant),
        .wd_rdy    (wd_rdy),
        .cmd_req   (cmd_req),
        .cmd_addr  (cmd_addr),
        .wd_wren   (wd_wren),
        .pop       (buf_pop)
    );

    always_comb begin
        top_d     = top_q;
        top_d.ovf = top_q.ovf || buf_drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign wd_last     = wd_wren;
    assign wr_overflow = top_q.ovf;

endmodule

// File: rtl/mwb_write_path_chk.sv
module mwb_write_path_chk #(
    parameter int DATA_W    = 128,
    parameter int ADDR_W    = 28,
    parameter int ADDR_STEP = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_req,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cmd_grant,
    input logic [DATA_W-1:0] wd_data,
    input logic              wd_wren,
    input logic              wd_rdy,
    input logic              wr_overflow
);

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_wren && !wd_rdy) |=> (wd_wren && $stable(wd_data))); // R4

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_grant) |=> (cmd_req && $stable(cmd_addr))); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_grant) |=> (cmd_addr == ADDR_W'($past(cmd_addr) + ADDR_STEP))); // R8

    AST_BEAT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !cmd_grant && wd_wren && wd_rdy) |=> (cmd_req && !wd_wren)); // R6

    AST_CMD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_grant && wd_wren && !wd_rdy) |=> (!cmd_req && wd_wren)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_overflow |=> wr_overflow); // R9

endmodule

bind mwb_write_path mwb_write_path_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .ADDR_STEP (ADDR_STEP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_req     (cmd_req),
    .cmd_addr    (cmd_addr),
    .cmd_grant   (cmd_grant),
    .wd_data     (wd_data),
    .wd_wren     (wd_wren),
    .wd_rdy      (wd_rdy),
    .wr_overflow (wr_overflow)
);

// File: tb/mwb_write_path_test.sv
`timescale 1ns/1ps
module mwb_write_path_test;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_en;
    logic [127:0] in_data;
    logic         cmd_req;
    logic [27:0]  cmd_addr;
    logic         cmd_grant;
    logic [127:0] wd_data;
    logic         wd_wren;
    logic         wd_last;
    logic         wd_rdy;
    logic         wr_overflow;

    int checks = 0;
    int fails  = 0;
    int word_idx = 0;
    logic [127:0] exp_q [$];
    logic [27:0]  exp_addr = 28'd8;
    bit done = 0;

    always #2.5 clk = ~clk;

    mwb_write_path uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_en       (in_en),
        .in_data     (in_data),
        .cmd_req     (cmd_req),
        .cmd_addr    (cmd_addr),
        .cmd_grant   (cmd_grant),
        .wd_data     (wd_data),
        .wd_wren     (wd_wren),
        .wd_last     (wd_last),
        .wd_rdy      (wd_rdy),
        .wr_overflow (wr_overflow)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] make_word(input int n);
        return {32'hC0DE0000 + 32'(n), 32'(n) ^ 32'h5A5A5A5A, ~32'(n), 32'(n * 7)};
    endfunction

    task automatic push_word(input bit keep);
        logic [127:0] w;
        w = make_word(word_idx);
        word_idx++;
        @(negedge clk);
        in_en   = 1'b1;
        in_data = w;
        if (keep) exp_q.push_back(w);
        @(negedge clk);
        in_en = 1'b0;
    endtask

    task automatic wait_req();
        int n = 0;
        while (!cmd_req && n < 40) begin
            @(negedge clk);
            n++;
        end
        check("R3 request raised", 128'(cmd_req), 128'd1);
    endtask

    task automatic expect_head(input string req);
        logic [127:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 128'hx;
        check(req, wd_data, e);
    endtask

    task automatic check_addr();
        check("R8 command address", 128'(cmd_addr), 128'(exp_addr));
        exp_addr = exp_addr + 28'd8;
    endtask

    // Command and data beat taken in the same cycle
    task automatic drain_both();
        wait_req();
        check("R6 data offered with request", 128'(wd_wren), 128'd1);
        check("R5 last follows wren", 128'(wd_last), 128'(wd_wren));
        check_addr();
        expect_head("R2 word order");
        cmd_grant = 1'b1;
        wd_rdy    = 1'b1;
        @(negedge clk);
        cmd_grant = 1'b0;
        wd_rdy    = 1'b0;
        check("R3 no repeat request", 128'(cmd_req), 128'd0);
        check("R3 no repeat beat", 128'(wd_wren), 128'd0);
    endtask

    // Data beat one cycle ahead of command
    task automatic drain_data_first();
        wait_req();
        expect_head("R2 word order, beat first");
        wd_rdy = 1'b1;
        @(negedge clk);
        wd_rdy = 1'b0;
        check("R6 request kept after early beat", 128'(cmd_req), 128'd1);
        check("R6 wren dropped after early beat", 128'(wd_wren), 128'd0);
        check("R5 last dropped with wren", 128'(wd_last), 128'd0);
        check_addr();
        cmd_grant = 1'b1;
        @(negedge clk);
        cmd_grant = 1'b0;
        check("R3 request ends after grant", 128'(cmd_req), 128'd0);
        check("R3 no second beat", 128'(wd_wren), 128'd0);
    endtask

    // Command taken first, ready arrives lag cycles later
    task automatic drain_late(input int lag);
        logic [127:0] held;
        wait_req();
        check_addr();
        cmd_grant = 1'b1;
        @(negedge clk);
        cmd_grant = 1'b0;
        check("R7 request dropped after grant", 128'(cmd_req), 128'd0);
        check("R7 wren kept after grant", 128'(wd_wren), 128'd1);
        held = wd_data;
        for (int i = 1; i < lag; i++) begin
            @(negedge clk);
            check("R4 wren held waiting ready", 128'(wd_wren), 128'd1);
            check("R4 data held waiting ready", wd_data, held);
            check("R5 last held with wren", 128'(wd_last), 128'd1);
        end
        expect_head("R2 word order, late ready");
        wd_rdy = 1'b1;
        @(negedge clk);
        wd_rdy = 1'b0;
        check("R3 beat finished once", 128'(wd_wren), 128'd0);
    endtask

    task automatic t_reset_state();
        check("R1 cmd_req in reset", 128'(cmd_req), 128'd0);
        check("R1 wd_wren in reset", 128'(wd_wren), 128'd0);
        check("R1 wd_last in reset", 128'(wd_last), 128'd0);
        check("R1 overflow in reset", 128'(wr_overflow), 128'd0);
        check("R1 address in reset", 128'(cmd_addr), 128'd8);
    endtask

    task automatic t_same_cycle();
        for (int i = 0; i < 3; i++) push_word(1);
        for (int i = 0; i < 3; i++) drain_both();
    endtask

    task automatic t_mixed_orders();
        for (int i = 0; i < 4; i++) push_word(1);
        drain_data_first();
        drain_data_first();
        drain_late(2);
        drain_late(5);
        repeat (4) @(negedge clk);
        check("R3 nothing left after mixed drain", 128'(cmd_req), 128'd0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 512; i++) push_word(1);
        check("R9 no overflow at 512 words", 128'(wr_overflow), 128'd0);
        push_word(0);
        check("R9 overflow after extra word", 128'(wr_overflow), 128'd1);
        for (int i = 0; i < 512; i++) drain_both();
        repeat (5) @(negedge clk);
        check("R9 dropped word never requested", 128'(cmd_req), 128'd0);
        check("R9 overflow sticky", 128'(wr_overflow), 128'd1);
    endtask

    task automatic t_reset_mid();
        push_word(1);
        push_word(1);
        wait_req();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 request stops on reset", 128'(cmd_req), 128'd0);
        check("R10 wren stops on reset", 128'(wd_wren), 128'd0);
        check("R10 overflow cleared", 128'(wr_overflow), 128'd0);
        exp_q.delete();
        exp_addr = 28'd8;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R10 buffer emptied", 128'(cmd_req), 128'd0);
        push_word(1);
        drain_both();
    endtask

    initial begin
        rst_n     = 1'b0;
        in_en     = 1'b0;
        in_data   = '0;
        cmd_grant = 1'b0;
        wd_rdy    = 1'b0;
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_same_cycle();
        t_mixed_orders();
        t_overflow();
        t_reset_mid();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule